// File: doc/BRIEF.md
# Cipher-Based Random Generator Reseed Controller

This block is the control and register layer in front of a keystream cipher engine used as a random generator. After software sets the enable bit, the block asks an entropy source for a 512-bit seed over a request/syn/ack handshake. It splits the seed into key, IV and starting counter, and starts the engine with the programmed round count. It then buffers each 512-bit output block and hands it out one 32-bit word per read of the random-data register.

The block counts the blocks it has taken from the engine. When a buffered block is used up, it either asks the engine for the next block or, if the count has reached the programmable 64-bit limit or software has asked for it, fetches a fresh seed and restarts the engine. A discard input throws away the buffered block. Clearing enable parks the block.

Top module: `rng_reseed_ctrl`

## Requirements
- R1: After reset, more_seed, seed_ack, eng_init, eng_next and err are low, the status word reads 0, the control word reads 0, the round count reads 8 and the block limit reads 0x0000_0001_0000_0000.
- R2: Reads return the identity word at 0x00 and the version word at 0x01. The round count (0x0C, low 5 bits), limit low (0x0D) and limit high (0x0E) read back what was written.
- R3: During the cycle of an access, err is high for any address outside {0x00,0x01,0x04,0x05,0x08,0x0C,0x0D,0x0E,0x10,0x11}, and for a write to 0x00, 0x01, 0x05, 0x08, 0x10 or 0x11. err is never high without cs.
- R4: Setting control bit 0 (enable, address 0x04) raises more_seed with no further command. A seed is taken only while more_seed and seed_syn are both high. Each seed taken is answered by exactly one cycle of seed_ack, and more_seed is low during that cycle.
- R5: The seed is mapped as key = seed[255:0] XOR {128'b0, seed[511:384]}, IV = seed[319:256] and counter = seed[383:320]. The engine is then started with eng_init and the current round count.
- R6: Status bit 0 (address 0x05) is high while a buffered word is available. Each read of 0x08 returns the next word, with word 0 taken from block bits [31:0], and consumes it. After the last word the next block is requested with eng_next.
- R7: A read of 0x08 while no word is available returns 0 and consumes nothing.
- R8: The produced-block count (low word 0x10, high word 0x11) rises by one per block taken from the engine and clears when a seed is taken.
- R9: When a block is used up and the produced count is at or above the limit, the block fetches a new seed instead of issuing eng_next. A limit of 1 reseeds after every block.
- R10: Writing control bit 1 sets a pending reseed request, which reads back in bit 1. It is served at the next block boundary and clears when the seed is taken.
- R11: A high cycle on discard drops the buffered block, and the following block is fetched.
- R12: Clearing enable drops the buffered block and lowers more_seed, and no further seed is requested.
- R13: eng_init and eng_next are never high together, and each is issued only while eng_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access select |
| we | input | 1 | Write when high, read when low |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the access cycle |
| err | output | 1 | Access error for this cycle |
| discard | input | 1 | Drop the buffered block |
| more_seed | output | 1 | Seed wanted |
| seed_syn | input | 1 | Seed offered |
| seed_data | input | 512 | Seed word |
| seed_ack | output | 1 | Seed taken (one cycle) |
| eng_init | output | 1 | Start engine with new key/IV/counter |
| eng_next | output | 1 | Ask engine for the next block |
| eng_key | output | 256 | Engine key |
| eng_iv | output | 64 | Engine IV |
| eng_ctr | output | 64 | Engine start counter |
| eng_rounds | output | 5 | Engine round count |
| eng_ready | input | 1 | Engine idle |
| eng_data | input | 512 | Engine output block |
| eng_valid | input | 1 | Engine output block valid |

## Verification
The assertions assume that the seed supplier holds seed_syn until it sees seed_ack and drops it right after. They also assume that the engine lowers eng_valid on the edge where it accepts eng_init or eng_next and keeps eng_ready low while it works. The bench's seed supplier and engine stub follow exactly these rules. The stub derives every output word from the key, IV, counter and round count it was started with, which makes the expected words computable from the seed index and block number. Register accesses last one cycle each, and discard is a single-cycle pulse.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 32;

  localparam logic [ADDR_W-1:0] A_ID     = 8'h00;
  localparam logic [ADDR_W-1:0] A_VER    = 8'h01;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h05;
  localparam logic [ADDR_W-1:0] A_RAND   = 8'h08;
  localparam logic [ADDR_W-1:0] A_ROUNDS = 8'h0C;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 8'h0D;
  localparam logic [ADDR_W-1:0] A_LIM_HI = 8'h0E;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 8'h10;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 8'h11;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEED  = 3'd1,
    ST_INIT  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_SERVE = 3'd4
  } ctl_st_t;
endpackage

// File: rtl/rng_seed_split.sv
module rng_seed_split #(
  parameter int SEED_W = 512,
  parameter int KEY_W  = 256,
  parameter int IV_W   = 64,
  parameter int CTR_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEED_W-1:0] seed,
  output logic [KEY_W-1:0]  key,
  output logic [IV_W-1:0]   iv,
  output logic [CTR_W-1:0]  ctr
);
  localparam int REM_W  = SEED_W - KEY_W - IV_W - CTR_W;
  localparam int IV_LO  = KEY_W;
  localparam int CTR_LO = KEY_W + IV_W;

  logic [KEY_W-1:0] key_d;
  logic [KEY_W-1:0] key_q;
  logic [IV_W-1:0]  iv_q;
  logic [CTR_W-1:0] ctr_q;

  generate
    if (REM_W > 0) begin : g_fold
      always_comb begin
        key_d = seed[KEY_W-1:0];
        key_d[REM_W-1:0] = key_d[REM_W-1:0] ^ seed[SEED_W-1 -: REM_W];
      end
    end else begin : g_plain
      assign key_d = seed[KEY_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      iv_q  <= '0;
      ctr_q <= '0;
    end else if (load) begin
      key_q <= key_d;
      iv_q  <= seed[IV_LO +: IV_W];
      ctr_q <= seed[CTR_LO +: CTR_W];
    end
  end

  assign key = key_q;
  assign iv  = iv_q;
  assign ctr = ctr_q;
endmodule

// File: rtl/rng_word_buf.sv
module rng_word_buf #(
  parameter int BLK_W  = 512,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  blk,
  input  logic              pop,
  input  logic              flush,
  output logic              valid,
  output logic [WORD_W-1:0] word
);
  localparam int NWORDS = BLK_W / WORD_W;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NWORDS - 1);

  logic [BLK_W-1:0] blk_q, blk_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d;
  logic             blk_en;

  always_comb begin
    blk_d  = blk_q;
    blk_en = 1'b0;
    idx_d  = idx_q;
    vld_d  = vld_q;
    if (flush) begin
      vld_d = 1'b0;
    end else if (load) begin
      blk_d  = blk;
      blk_en = 1'b1;
      idx_d  = '0;
      vld_d  = 1'b1;
    end else if (pop && vld_q) begin
      if (idx_q == IDX_LAST) begin
        vld_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_en) begin
      blk_q <= blk_d;
    end
  end

  assign valid = vld_q;
  assign word  = vld_q ? blk_q[idx_q*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/rng_blk_count.sv
module rng_blk_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             incr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (incr) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count    = cnt_q;
  assign at_limit = (cnt_q >= limit);
endmodule

// File: rtl/rng_reseed_ctrl.sv
module rng_reseed_ctrl
  import rng_pkg::*;
#(
  parameter int          SEED_W     = 512,
  parameter int          KEY_W      = 256,
  parameter int          IV_W       = 64,
  parameter int          CTR_W      = 64,
  parameter int          BLK_W      = 512,
  parameter int          RND_W      = 5,
  parameter int          DEF_ROUNDS = 8,
  parameter logic [63:0] DEF_LIMIT  = 64'h0000_0001_0000_0000,
  parameter logic [31:0] ID_WORD    = 32'h524E_4731,
  parameter logic [31:0] VER_WORD   = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              err,
  input  logic              discard,
  output logic              more_seed,
  input  logic              seed_syn,
  input  logic [SEED_W-1:0] seed_data,
  output logic              seed_ack,
  output logic              eng_init,
  output logic              eng_next,
  output logic [KEY_W-1:0]  eng_key,
  output logic [IV_W-1:0]   eng_iv,
  output logic [CTR_W-1:0]  eng_ctr,
  output logic [RND_W-1:0]  eng_rounds,
  input  logic              eng_ready,
  input  logic [BLK_W-1:0]  eng_data,
  input  logic              eng_valid
);
  localparam int CNT_W = 2 * REG_W;
  localparam int PAD_W = REG_W - RND_W;

  ctl_st_t          st_q, st_d;
  logic             en_q, en_d;
  logic             rsd_req_q, rsd_req_d;
  logic [RND_W-1:0] rounds_q, rounds_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             ack_q;

  logic             rd_acc, wr_acc, known, ro;
  logic             seed_take, init_go, next_go, capture;
  logic             buf_valid, buf_pop, buf_flush;
  logic [REG_W-1:0] buf_word;
  logic [CNT_W-1:0] blk_cnt;
  logic             at_limit;

  assign rd_acc = cs && !we;
  assign wr_acc = cs && we;

  // address decode
  always_comb begin
    known = 1'b1;
    ro    = 1'b0;
    case (addr)
      A_ID, A_VER, A_STAT, A_RAND, A_CNT_LO, A_CNT_HI: ro = 1'b1;
      A_CTRL, A_ROUNDS, A_LIM_LO, A_LIM_HI:             ro = 1'b0;
      default:                                          known = 1'b0;
    endcase
  end

  assign err = cs && (!known || (we && ro));

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      case (addr)
        A_ID:     rdata = ID_WORD;
        A_VER:    rdata = VER_WORD;
        A_CTRL:   rdata = {{(REG_W-2){1'b0}}, rsd_req_q, en_q};
        A_STAT:   rdata = {{(REG_W-1){1'b0}}, buf_valid};
        A_RAND:   rdata = buf_word;
        A_ROUNDS: rdata = {{PAD_W{1'b0}}, rounds_q};
        A_LIM_LO: rdata = lim_q[REG_W-1:0];
        A_LIM_HI: rdata = lim_q[CNT_W-1:REG_W];
        A_CNT_LO: rdata = blk_cnt[REG_W-1:0];
        A_CNT_HI: rdata = blk_cnt[CNT_W-1:REG_W];
        default:  rdata = '0;
      endcase
    end
  end

  // software registers, next state
  always_comb begin
    en_d      = en_q;
    rsd_req_d = rsd_req_q;
    rounds_d  = rounds_q;
    lim_d     = lim_q;
    if (seed_take) begin
      rsd_req_d = 1'b0;
    end
    if (wr_acc) begin
      case (addr)
        A_CTRL: begin
          en_d = wdata[0];
          if (wdata[1]) begin
            rsd_req_d = 1'b1;
          end
        end
        A_ROUNDS: rounds_d = wdata[RND_W-1:0];
        A_LIM_LO: lim_d[REG_W-1:0] = wdata;
        A_LIM_HI: lim_d[CNT_W-1:REG_W] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rsd_req_q <= 1'b0;
      rounds_q  <= RND_W'(DEF_ROUNDS);
      lim_q     <= DEF_LIMIT;
    end else begin
      en_q      <= en_d;
      rsd_req_q <= rsd_req_d;
      rounds_q  <= rounds_d;
      lim_q     <= lim_d;
    end
  end

  // sequencing
  always_comb begin
    st_d      = st_q;
    seed_take = 1'b0;
    init_go   = 1'b0;
    next_go   = 1'b0;
    capture   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_q) st_d = ST_SEED;
      end
      ST_SEED: begin
        if (!en_q) begin
          st_d = ST_IDLE;
        end else if (seed_syn) begin
          seed_take = 1'b1;
          st_d      = ST_INIT;
        end
      end
      ST_INIT: begin
        if (!en_q) begin
          st_d = ST_IDLE;
        end else if (eng_ready) begin
          init_go = 1'b1;
          st_d    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!en_q) begin
          st_d = ST_IDLE;
        end else if (eng_valid) begin
          capture = 1'b1;
          st_d    = ST_SERVE;
        end
      end
      ST_SERVE: begin
        if (!en_q) begin
          st_d = ST_IDLE;
        end else if (!buf_valid) begin
          if (rsd_req_q || at_limit) begin
            st_d = ST_SEED;
          end else if (eng_ready) begin
            next_go = 1'b1;
            st_d    = ST_WAIT;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= seed_take;
    end
  end

  assign more_seed  = (st_q == ST_SEED);
  assign seed_ack   = ack_q;
  assign eng_init   = init_go;
  assign eng_next   = next_go;
  assign eng_rounds = rounds_q;

  assign buf_pop   = rd_acc && (addr == A_RAND);
  assign buf_flush = discard || !en_q;

  rng_seed_split #(
    .SEED_W(SEED_W), .KEY_W(KEY_W), .IV_W(IV_W), .CTR_W(CTR_W)
  ) u_split (
    .clk(clk), .rst_n(rst_n), .load(seed_take), .seed(seed_data),
    .key(eng_key), .iv(eng_iv), .ctr(eng_ctr)
  );

  rng_word_buf #(
    .BLK_W(BLK_W), .WORD_W(REG_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .load(capture), .blk(eng_data),
    .pop(buf_pop), .flush(buf_flush), .valid(buf_valid), .word(buf_word)
  );

  rng_blk_count #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(seed_take), .incr(capture),
    .limit(lim_q), .count(blk_cnt), .at_limit(at_limit)
  );
endmodule

// File: rtl/rng_reseed_chk.sv
module rng_reseed_chk
  import rng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  rdata,
  input logic              err,
  input logic              more_seed,
  input logic              seed_syn,
  input logic              seed_ack,
  input logic              eng_init,
  input logic              eng_next,
  input logic              eng_ready,
  input logic              buf_valid,
  input logic              en_q
);
  // R4: ack lasts one cycle
  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ack |=> !seed_ack);
  // R4: ack answers an offered seed that was requested
  p_ack_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ack |-> ($past(more_seed) && $past(seed_syn) && !more_seed));
  // R13: engine commands exclusive
  p_eng_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_init, eng_next}));
  // R13: engine commands only when ready
  p_eng_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_init || eng_next) |-> eng_ready);
  // R3: error only inside an access
  p_err_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cs);
  // R7: empty random register reads zero
  p_rand_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == A_RAND && !buf_valid) |-> (rdata == '0));
  // R12: disabled block stops requesting seed
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !more_seed);
endmodule

bind rng_reseed_ctrl rng_reseed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .rdata(rdata),
  .err(err), .more_seed(more_seed), .seed_syn(seed_syn), .seed_ack(seed_ack),
  .eng_init(eng_init), .eng_next(eng_next), .eng_ready(eng_ready),
  .buf_valid(buf_valid), .en_q(en_q)
);

// File: tb/tb_rng_reseed_ctrl.sv
`timescale 1ns/1ps
module eng_stub #(
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         next,
  input  logic [255:0] key,
  input  logic [63:0]  iv,
  input  logic [63:0]  ctr,
  input  logic [4:0]   rounds,
  output logic         ready,
  output logic [511:0] data,
  output logic         valid
);
  logic [31:0] k_q, v_q, c_q;
  logic [4:0]  r_q;
  logic        busy_q, vld_q;
  logic [7:0]  tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= '0; v_q <= '0; c_q <= '0; r_q <= '0;
      busy_q <= 1'b0; vld_q <= 1'b0; tmr_q <= '0;
    end else if (init) begin
      k_q <= key[31:0]; v_q <= iv[31:0]; c_q <= ctr[31:0]; r_q <= rounds;
      busy_q <= 1'b1; vld_q <= 1'b0; tmr_q <= 8'(LAT);
    end else if (next) begin
      c_q <= c_q + 1;
      busy_q <= 1'b1; vld_q <= 1'b0; tmr_q <= 8'(LAT);
    end else if (busy_q) begin
      if (tmr_q == 0) begin
        busy_q <= 1'b0;
        vld_q  <= 1'b1;
      end else begin
        tmr_q <= tmr_q - 1;
      end
    end
  end

  for (genvar i = 0; i < 16; i++) begin : g_w
    assign data[i*32 +: 32] = k_q ^ v_q ^ c_q ^ {27'b0, r_q} ^ (32'(i) * 32'h01010101);
  end
  assign ready = !busy_q;
  assign valid = vld_q;
endmodule

module tb_rng_reseed_ctrl;
  import rng_pkg::*;

  logic         clk, rst_n, cs, we, err, discard;
  logic [7:0]   addr;
  logic [31:0]  wdata, rdata;
  logic         more_seed, seed_syn, seed_ack;
  logic [511:0] seed_data, eng_data;
  logic         eng_init, eng_next, eng_ready, eng_valid;
  logic [255:0] eng_key;
  logic [63:0]  eng_iv, eng_ctr;
  logic [4:0]   eng_rounds;

  int n_chk = 0, n_bad = 0, cyc = 0, seeds_given = 0;
  logic [31:0] d;
  logic        e;

  rng_reseed_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .err(err), .discard(discard), .more_seed(more_seed),
    .seed_syn(seed_syn), .seed_data(seed_data), .seed_ack(seed_ack),
    .eng_init(eng_init), .eng_next(eng_next), .eng_key(eng_key), .eng_iv(eng_iv),
    .eng_ctr(eng_ctr), .eng_rounds(eng_rounds), .eng_ready(eng_ready),
    .eng_data(eng_data), .eng_valid(eng_valid)
  );

  eng_stub u_eng (
    .clk(clk), .rst_n(rst_n), .init(eng_init), .next(eng_next), .key(eng_key),
    .iv(eng_iv), .ctr(eng_ctr), .rounds(eng_rounds), .ready(eng_ready),
    .data(eng_data), .valid(eng_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] sw(int idx, int j);
    return {8'(idx), 8'h5A, 8'(j), 8'hC3};
  endfunction

  function automatic logic [511:0] mk_seed(int idx);
    logic [511:0] s;
    for (int j = 0; j < 16; j++) s[j*32 +: 32] = sw(idx, j);
    return s;
  endfunction

  // R5 mapping: key low word = w0^w12, iv low = w8, counter low = w10
  function automatic logic [31:0] exp_word(int idx, int b, int i, int rnd);
    logic [31:0] k, v, c;
    k = sw(idx, 0) ^ sw(idx, 12);
    v = sw(idx, 8);
    c = sw(idx, 10) + 32'(b);
    return k ^ v ^ c ^ 32'(rnd) ^ (32'(i) * 32'h01010101);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      n_bad++;
      $display("FAIL watchdog R1..R13 actual=%0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  // seed supplier
  initial begin
    seed_syn  = 1'b0;
    seed_data = '0;
    forever begin
      wait (more_seed === 1'b1);
      @(negedge clk);
      seed_data = mk_seed(seeds_given);
      seed_syn  = 1'b1;
      do @(negedge clk); while (seed_ack !== 1'b1);
      seed_syn = 1'b0;
      seeds_given++;
    end
  end

  task automatic rd(input logic [7:0] a, output logic [31:0] dv, output logic ev);
    cs = 1'b1; we = 1'b0; addr = a;
    #1; dv = rdata; ev = err;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v, output logic ev);
    cs = 1'b1; we = 1'b1; addr = a; wdata = v;
    #1; ev = err;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic wait_valid(string req);
    logic [31:0] sv;
    logic        se;
    for (int k = 0; k < 400; k++) begin
      rd(A_STAT, sv, se);
      if (sv[0]) return;
    end
    check(req, 32'h0, 32'h1);
  endtask

  task automatic get_word(string req, logic [31:0] exp);
    logic [31:0] wv;
    logic        we_;
    wait_valid(req);
    rd(A_RAND, wv, we_);
    check(req, wv, exp);
  endtask

  // {req[3:0], we, chk, err, addr[7:0], wdata[31:0], exp[31:0]}
  localparam int NV = 20;
  localparam logic [78:0] VEC [0:NV-1] = '{
    {4'd2,  1'b0, 1'b1, 1'b0, A_ID,     32'h0,  32'h524E_4731},
    {4'd2,  1'b0, 1'b1, 1'b0, A_VER,    32'h0,  32'h0000_0100},
    {4'd1,  1'b0, 1'b1, 1'b0, A_ROUNDS, 32'h0,  32'd8},
    {4'd1,  1'b0, 1'b1, 1'b0, A_LIM_LO, 32'h0,  32'h0},
    {4'd1,  1'b0, 1'b1, 1'b0, A_LIM_HI, 32'h0,  32'h1},
    {4'd2,  1'b1, 1'b0, 1'b0, A_ROUNDS, 32'd12, 32'h0},
    {4'd2,  1'b0, 1'b1, 1'b0, A_ROUNDS, 32'h0,  32'd12},
    {4'd2,  1'b1, 1'b0, 1'b0, A_LIM_LO, 32'd3,  32'h0},
    {4'd2,  1'b1, 1'b0, 1'b0, A_LIM_HI, 32'd0,  32'h0},
    {4'd2,  1'b0, 1'b1, 1'b0, A_LIM_LO, 32'h0,  32'd3},
    {4'd2,  1'b0, 1'b1, 1'b0, A_LIM_HI, 32'h0,  32'd0},
    {4'd3,  1'b0, 1'b0, 1'b1, 8'h3F,    32'h0,  32'h0},
    {4'd3,  1'b1, 1'b0, 1'b1, A_STAT,   32'h1,  32'h0},
    {4'd3,  1'b1, 1'b0, 1'b1, A_ID,     32'h1,  32'h0},
    {4'd7,  1'b0, 1'b1, 1'b0, A_RAND,   32'h0,  32'h0},
    {4'd1,  1'b0, 1'b1, 1'b0, A_STAT,   32'h0,  32'h0},
    {4'd8,  1'b0, 1'b1, 1'b0, A_CNT_LO, 32'h0,  32'h0},
    {4'd1,  1'b0, 1'b1, 1'b0, A_CTRL,   32'h0,  32'h0},
    {4'd3,  1'b1, 1'b0, 1'b1, A_CNT_HI, 32'h5,  32'h0},
    {4'd3,  1'b0, 1'b0, 1'b1, 8'h09,    32'h0,  32'h0}
  };

  initial begin
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0; discard = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset outputs
    check("R1 more_seed", 32'(more_seed), 32'h0);
    check("R1 seed_ack", 32'(seed_ack), 32'h0);
    check("R1 eng_cmd", 32'({eng_init, eng_next}), 32'h0);
    check("R1 err", 32'(err), 32'h0);

    // register table: R1 R2 R3 R7 R8
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v][78:75], v);
      if (VEC[v][74]) begin
        wr(VEC[v][71:64], VEC[v][63:32], e);
      end else begin
        rd(VEC[v][71:64], d, e);
        if (VEC[v][73]) check(tag, d, VEC[v][31:0]);
      end
      check({tag, " err"}, 32'(e), 32'(VEC[v][72]));
    end

    // R4 enable starts seeding, R5 R6 words in order, R9 limit 3
    wr(A_CTRL, 32'h1, e);
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 16; i++) begin
        get_word("R6 R9 word", (k < 3) ? exp_word(0, k, i, 12) : exp_word(1, 0, i, 12));
      end
    end
    check("R4 seeds taken", 32'(seeds_given), 32'd2);
    wait_valid("R6 refill");
    rd(A_CNT_LO, d, e);
    check("R8 count lo", d, 32'd2);
    rd(A_CNT_HI, d, e);
    check("R8 count hi", d, 32'd0);

    // R11 discard
    get_word("R11 before", exp_word(1, 1, 0, 12));
    discard = 1'b1;
    @(negedge clk);
    discard = 1'b0;
    get_word("R11 after", exp_word(1, 2, 0, 12));
    for (int i = 1; i < 16; i++) get_word("R11 rest", exp_word(1, 2, i, 12));
    get_word("R9 reseed", exp_word(2, 0, 0, 12));
    check("R4 seeds taken", 32'(seeds_given), 32'd3);

    // R10 software reseed, R5 rounds at init
    wr(A_CTRL, 32'h3, e);
    rd(A_CTRL, d, e);
    check("R10 pending", d, 32'h3);
    wr(A_ROUNDS, 32'd20, e);
    for (int i = 1; i < 16; i++) get_word("R10 drain", exp_word(2, 0, i, 12));
    get_word("R10 R5 new seed", exp_word(3, 0, 0, 20));
    rd(A_CTRL, d, e);
    check("R10 cleared", d, 32'h1);
    rd(A_CNT_LO, d, e);
    check("R8 cleared", d, 32'd1);

    // R9 limit of one
    wr(A_LIM_LO, 32'd1, e);
    for (int i = 1; i < 16; i++) get_word("R9 drain", exp_word(3, 0, i, 20));
    get_word("R9 limit1", exp_word(4, 0, 0, 20));
    check("R9 seeds", 32'(seeds_given), 32'd5);

    // R12 disable
    wr(A_CTRL, 32'h0, e);
    repeat (3) @(negedge clk);
    rd(A_STAT, d, e);
    check("R12 status", d, 32'h0);
    rd(A_RAND, d, e);
    check("R12 R7 rand", d, 32'h0);
    repeat (20) @(negedge clk);
    check("R12 more_seed", 32'(more_seed), 32'h0);
    check("R12 seeds", 32'(seeds_given), 32'd5);

    summary();
    $finish;
  end
endmodule